// File: doc/BRIEF.md
# Crystal Oscillator Control and RC Trim Register

This block is the control and status word for an external crystal oscillator, together with the trim of an internal RC oscillator. Software sets the oscillator enable, power-up and bypass controls through a single-word write port and reads them back with a live stability flag, a software trim adjust and a factory calibration byte. The block's outputs drive the oscillator's analog front end and the RC trim inputs.

The block watches the live clock tree and drops parts of a write that would be unsafe. The bypass control changes only while the oscillator is fully off. The enable cannot be cleared while the oscillator clocks the system, either directly or through the PLL when the PLL is the system clock. A standby-entry pulse clears the enable in hardware. The RC trim code is the calibration byte plus the adjust field, clamped at full scale.

Top module: `osc_ctl_top`

## Requirements
- R1: During and right after a synchronous reset, the enable, power-up and bypass controls read 0, the adjust field reads `ADJ_RST` (default 0), and the calibration field holds the value on `cal_por_i` captured during reset.
- R2: A write changes the bypass control (read bit 2) only if the enable (bit 0) and power-up (bit 1) controls are both 0 in the cycle of the write. Otherwise bypass keeps its value.
- R3: A write of 0 to the enable bit is ignored when `sys_src_i` is 2'b01 (crystal is the system clock), or when `sys_src_i` is 2'b10 (PLL is the system clock) and `pll_src_xo_i` is 1. With any other source, the clear takes effect.
- R4: A cycle with `standby_i` high leaves the enable at 0 in the next cycle, even if a write sets it in that same cycle.
- R5: Read bit 3 (stable flag) equals `xo_stable_i` while the enable is 1 and reads 0 while the enable is 0. Writes do not affect it.
- R6: The calibration field (read bits 23:16) ignores writes. It changes only when reset captures `cal_por_i`.
- R7: `rc_trim_o` equals the calibration value plus the 5-bit adjust field (read bits 12:8), saturated at 255.
- R8: When an interlock blocks one control, the other fields of the same write (power-up, adjust, and any unblocked control) still update in the next cycle.
- R9: Read bits 31:24, 15:13 and 7:4 always read 0. `xo_en_o`, `xo_pwr_o` and `xo_bypass_o` equal read bits 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data |
| sys_src_i | input | 2 | System clock source: 00 RC, 01 crystal, 10 PLL |
| pll_src_xo_i | input | 1 | PLL reference is the crystal |
| standby_i | input | 1 | Standby-entry pulse |
| xo_stable_i | input | 1 | Oscillator reports stable |
| cal_por_i | input | 8 | Factory calibration value, captured during reset |
| rd_data_o | output | 32 | Read view of the control word |
| xo_en_o | output | 1 | Oscillator enable |
| xo_pwr_o | output | 1 | Oscillator power-up |
| xo_bypass_o | output | 1 | Oscillator bypass |
| rc_trim_o | output | 8 | RC trim code |

## Verification
The bench writes bypass while the enable or power-up control is set, including the cycle right after power-up is cleared. A design that checks the incoming data rather than the stored state would let bypass change there. It tries to clear the enable under each clock-source combination. A design that ignores the PLL path would stop the system clock, and one that locks on the wrong source would leave the oscillator on. It also drives standby together with an enable write, applies a maximum adjust on a high calibration value, and changes `cal_por_i` outside reset. These cases expose a write that wins over standby, a trim that wraps to a low code, and a calibration byte that follows its input.

// File: rtl/osc_ctl_pkg.sv
package osc_ctl_pkg;

    // Read-view bit positions. Software decodes these positions.
    localparam int unsigned EN_BIT  = 0;
    localparam int unsigned PWR_BIT = 1;
    localparam int unsigned BYP_BIT = 2;
    localparam int unsigned RDY_BIT = 3;
    localparam int unsigned ADJ_LSB = 8;
    localparam int unsigned CAL_LSB = 16;

    typedef enum logic [1:0] {
        SRC_RC  = 2'b00,
        SRC_XO  = 2'b01,
        SRC_PLL = 2'b10,
        SRC_RSV = 2'b11
    } clk_src_e;

    typedef struct packed {
        logic bypass;
        logic pwr;
        logic en;
    } xo_ctl_t;

    // True when turning the crystal off would stop the system clock.
    function automatic logic xo_in_use(clk_src_e src, logic pll_from_xo);
        return (src == SRC_XO) || ((src == SRC_PLL) && pll_from_xo);
    endfunction

endpackage

// File: rtl/osc_ctl_gate.sv
module osc_ctl_gate
    import osc_ctl_pkg::*;
(
    input  logic    we,
    input  xo_ctl_t wr_ctl,
    input  xo_ctl_t cur_ctl,
    input  logic    xo_busy,
    input  logic    stby,
    output xo_ctl_t nxt_ctl
);
    logic byp_open;
    logic en_accept;

    // Bypass may only move while the oscillator is fully off.
    assign byp_open  = !cur_ctl.en && !cur_ctl.pwr;
    // Setting the enable is always allowed; clearing it needs the clock tree off the crystal.
    assign en_accept = wr_ctl.en || !(cur_ctl.en && xo_busy);

    always_comb begin
        nxt_ctl = cur_ctl;
        if (we) begin
            nxt_ctl.pwr = wr_ctl.pwr;
            if (byp_open)  nxt_ctl.bypass = wr_ctl.bypass;
            if (en_accept) nxt_ctl.en     = wr_ctl.en;
        end
        if (stby) nxt_ctl.en = 1'b0;
    end
endmodule

// File: rtl/osc_ctl_trim.sv
module osc_ctl_trim #(
    parameter int unsigned CAL_W = 8,
    parameter int unsigned ADJ_W = 5,
    parameter bit          SAT   = 1'b1
) (
    input  logic [CAL_W-1:0] cal_i,
    input  logic [ADJ_W-1:0] adj_i,
    output logic [CAL_W-1:0] trim_o
);
    localparam int unsigned SUM_W = CAL_W + 1;
    localparam int unsigned PAD_W = SUM_W - ADJ_W;

    logic [SUM_W-1:0] sum;
    assign sum = {1'b0, cal_i} + {{PAD_W{1'b0}}, adj_i};

    generate
        if (SAT) begin : g_sat
            assign trim_o = sum[CAL_W] ? {CAL_W{1'b1}} : sum[CAL_W-1:0];
        end else begin : g_wrap
            logic unused_carry;
            assign unused_carry = sum[CAL_W];
            assign trim_o = sum[CAL_W-1:0];
        end
    endgenerate

    // R7: result never falls below either operand
    always_comb begin
        if (SAT) begin
            assert_trim_floor_R7: assert (trim_o >= cal_i && trim_o >= CAL_W'(adj_i));
        end
    end
endmodule

// File: rtl/osc_ctl_regs.sv
module osc_ctl_regs
    import osc_ctl_pkg::*;
#(
    parameter int unsigned            CAL_W   = 8,
    parameter int unsigned            ADJ_W   = 5,
    parameter logic [ADJ_W-1:0]       ADJ_RST = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  xo_ctl_t          wr_ctl,
    input  logic [ADJ_W-1:0] wr_adj,
    input  logic             xo_busy,
    input  logic             stby,
    input  logic [CAL_W-1:0] cal_por,
    output xo_ctl_t          ctl_q,
    output logic [ADJ_W-1:0] adj_q,
    output logic [CAL_W-1:0] cal_q
);
    xo_ctl_t ctl_nxt;

    osc_ctl_gate u_gate (
        .we      (we),
        .wr_ctl  (wr_ctl),
        .cur_ctl (ctl_q),
        .xo_busy (xo_busy),
        .stby    (stby),
        .nxt_ctl (ctl_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            adj_q <= ADJ_RST;
            cal_q <= cal_por;
        end else begin
            ctl_q <= ctl_nxt;
            if (we) adj_q <= wr_adj;
        end
    end

    assert_byp_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.en || ctl_q.pwr) |=> $stable(ctl_q.bypass));

    assert_en_lock_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.en && xo_busy && !stby) |=> ctl_q.en);

    assert_stby_clear_R4: assert property (@(posedge clk) disable iff (rst)
        stby |=> !ctl_q.en);

    assert_cal_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(cal_q));

    assert_pwr_follow_R8: assert property (@(posedge clk) disable iff (rst)
        we |=> (ctl_q.pwr == $past(wr_ctl.pwr) && adj_q == $past(wr_adj)));
endmodule

// File: rtl/osc_ctl_top.sv
module osc_ctl_top
    import osc_ctl_pkg::*;
#(
    parameter int unsigned      DATA_W   = 32,
    parameter int unsigned      CAL_W    = 8,
    parameter int unsigned      ADJ_W    = 5,
    parameter logic [ADJ_W-1:0] ADJ_RST  = '0,
    parameter bit               TRIM_SAT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        sys_src_i,
    input  logic              pll_src_xo_i,
    input  logic              standby_i,
    input  logic              xo_stable_i,
    input  logic [CAL_W-1:0]  cal_por_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              xo_en_o,
    output logic              xo_pwr_o,
    output logic              xo_bypass_o,
    output logic [CAL_W-1:0]  rc_trim_o
);
    xo_ctl_t          wr_ctl;
    xo_ctl_t          ctl_q;
    logic [ADJ_W-1:0] adj_q;
    logic [CAL_W-1:0] cal_q;
    logic             xo_busy;
    logic             rdy_flag;
    logic             wr_unused;

    assign wr_ctl.en     = wr_data_i[EN_BIT];
    assign wr_ctl.pwr    = wr_data_i[PWR_BIT];
    assign wr_ctl.bypass = wr_data_i[BYP_BIT];
    assign wr_unused     = ^wr_data_i;

    assign xo_busy = xo_in_use(clk_src_e'(sys_src_i), pll_src_xo_i);

    osc_ctl_regs #(
        .CAL_W   (CAL_W),
        .ADJ_W   (ADJ_W),
        .ADJ_RST (ADJ_RST)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en_i),
        .wr_ctl  (wr_ctl),
        .wr_adj  (wr_data_i[ADJ_LSB +: ADJ_W]),
        .xo_busy (xo_busy),
        .stby    (standby_i),
        .cal_por (cal_por_i),
        .ctl_q   (ctl_q),
        .adj_q   (adj_q),
        .cal_q   (cal_q)
    );

    osc_ctl_trim #(
        .CAL_W (CAL_W),
        .ADJ_W (ADJ_W),
        .SAT   (TRIM_SAT)
    ) u_trim (
        .cal_i  (cal_q),
        .adj_i  (adj_q),
        .trim_o (rc_trim_o)
    );

    assign rdy_flag = ctl_q.en && xo_stable_i;

    always_comb begin
        rd_data_o                     = '0;
        rd_data_o[EN_BIT]             = ctl_q.en;
        rd_data_o[PWR_BIT]            = ctl_q.pwr;
        rd_data_o[BYP_BIT]            = ctl_q.bypass;
        rd_data_o[RDY_BIT]            = rdy_flag;
        rd_data_o[ADJ_LSB +: ADJ_W]   = adj_q;
        rd_data_o[CAL_LSB +: CAL_W]   = cal_q;
    end

    assign xo_en_o     = ctl_q.en;
    assign xo_pwr_o    = ctl_q.pwr;
    assign xo_bypass_o = ctl_q.bypass;

    assert_rdy_gate_R5: assert property (@(posedge clk) disable iff (rst)
        !xo_en_o |-> !rd_data_o[RDY_BIT]);
endmodule

// File: tb/tb_osc_ctl_top.sv
`timescale 1ns/1ps
module tb_osc_ctl_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [1:0]  sys_src_i = 2'b00;
    logic        pll_src_xo_i = 1'b0;
    logic        standby_i = 1'b0;
    logic        xo_stable_i = 1'b0;
    logic [7:0]  cal_por_i = 8'h00;
    logic [31:0] rd_data_o;
    logic        xo_en_o, xo_pwr_o, xo_bypass_o;
    logic [7:0]  rc_trim_o;

    always #2.5 clk = ~clk;

    osc_ctl_top dut (
        .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .sys_src_i(sys_src_i), .pll_src_xo_i(pll_src_xo_i), .standby_i(standby_i),
        .xo_stable_i(xo_stable_i), .cal_por_i(cal_por_i), .rd_data_o(rd_data_o),
        .xo_en_o(xo_en_o), .xo_pwr_o(xo_pwr_o), .xo_bypass_o(xo_bypass_o),
        .rc_trim_o(rc_trim_o)
    );

    typedef struct {
        logic [31:0] rd;
        logic [7:0]  trim;
        logic [2:0]  ctl;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state kept from the requirements
    logic       m_en = 0, m_pwr = 0, m_byp = 0;
    logic [4:0] m_adj = 0;
    logic [7:0] m_cal = 0;

    function automatic logic [31:0] wd(logic en, logic pwr, logic byp, logic [4:0] adj);
        return {19'b0, adj, 5'b0, byp, pwr, en};
    endfunction

    function automatic logic [7:0] sat_trim(logic [7:0] c, logic [4:0] a);
        logic [8:0] s;
        s = {1'b0, c} + {4'b0, a};
        return s[8] ? 8'hFF : s[7:0];
    endfunction

    task automatic push_exp(input logic stab, input string tag);
        exp_t e;
        e.rd   = {8'b0, m_cal, 3'b0, m_adj, 4'b0, (m_en & stab), m_byp, m_pwr, m_en};
        e.trim = sat_trim(m_cal, m_adj);
        e.ctl  = {m_byp, m_pwr, m_en};
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic do_reset(input logic [7:0] cal, input string tag);
        @(negedge clk);
        rst = 1'b1; cal_por_i = cal; wr_en_i = 0; standby_i = 0; xo_stable_i = 0;
        m_en = 0; m_pwr = 0; m_byp = 0; m_adj = 0; m_cal = cal;
        push_exp(1'b0, tag);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic op(input logic we, input logic [31:0] d, input logic [1:0] src,
                      input logic pxo, input logic stby, input logic stab, input string tag);
        logic busy;
        @(negedge clk);
        wr_en_i = we; wr_data_i = d; sys_src_i = src; pll_src_xo_i = pxo;
        standby_i = stby; xo_stable_i = stab;
        busy = (src == 2'b01) || (src == 2'b10 && pxo);
        if (we) begin
            if (!m_en && !m_pwr) m_byp = d[2];
            if (d[0] || !(m_en && busy)) m_en = d[0];
            m_pwr = d[1];
            m_adj = d[12:8];
        end
        if (stby) m_en = 1'b0;
        push_exp(stab, tag);
    endtask

    // monitor: compare one expected item per cycle, just after the edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (rd_data_o !== e.rd || rc_trim_o !== e.trim ||
                {xo_bypass_o, xo_pwr_o, xo_en_o} !== e.ctl) begin
                errors++;
                $display("FAIL %s: rd=%h trim=%h ctl=%b expected rd=%h trim=%h ctl=%b",
                         e.tag, rd_data_o, rc_trim_o, {xo_bypass_o, xo_pwr_o, xo_en_o},
                         e.rd, e.trim, e.ctl);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(8'hF0, "R1 reset state");
        op(1, wd(0,0,1,5'h0A), 2'b00, 0, 0, 0, "R2 bypass set while off");
        op(1, wd(1,0,1,5'h0A), 2'b00, 0, 0, 0, "R2 enable with bypass kept");
        op(1, wd(1,0,0,5'h03), 2'b00, 0, 0, 0, "R2 R8 bypass blocked adj updates");
        op(0, 32'h0,           2'b00, 0, 0, 1, "R5 stable flag follows input");
        op(1, wd(0,1,1,5'h03), 2'b01, 0, 0, 1, "R3 R8 clear blocked on crystal source");
        op(1, wd(0,1,1,5'h04), 2'b10, 1, 0, 1, "R3 clear blocked via PLL");
        op(1, wd(0,1,1,5'h04), 2'b10, 0, 0, 1, "R3 R5 clear allowed when PLL not on crystal");
        op(1, wd(0,1,0,5'h04), 2'b00, 0, 0, 0, "R2 bypass blocked by power-up");
        op(1, wd(0,0,0,5'h04), 2'b00, 0, 0, 0, "R2 bypass blocked in cycle power-up drops");
        op(1, wd(0,0,0,5'h04), 2'b00, 0, 0, 0, "R2 bypass clear accepted");
        op(1, wd(1,0,0,5'h04), 2'b01, 0, 0, 1, "R3 enable while crystal is source");
        op(0, 32'h0,           2'b01, 0, 1, 1, "R4 standby clears enable");
        op(1, wd(1,0,0,5'h04), 2'b00, 0, 1, 1, "R4 standby wins over enable write");
        op(1, 32'h0000_1F08,   2'b00, 0, 0, 1, "R5 R6 R7 saturate, ro fields untouched");
        @(negedge clk); cal_por_i = 8'h20;
        op(0, 32'h0,           2'b00, 0, 0, 0, "R6 calibration ignores input outside reset");
        do_reset(8'h20, "R1 reset captures new calibration");
        op(1, wd(0,0,0,5'h0A), 2'b00, 0, 0, 0, "R7 unsaturated sum");
        op(1, wd(0,0,0,5'h1F), 2'b00, 0, 0, 0, "R7 max adjust no clamp");
        op(1, 32'hFFFF_FFFF,   2'b00, 0, 0, 1, "R9 unused bits read zero");
        op(1, wd(1,0,0,5'h1F), 2'b01, 0, 0, 1, "R2 R3 R8 bypass blocked, power-up clears");
        op(0, 32'h0,           2'b00, 0, 0, 0, "R5 stable flag drops with input");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule